// File: doc/BRIEF.md
# Shift-Scaled Delayed-LMS Weight Updater

This block keeps the N coefficient registers of a delayed least-mean-square adaptive filter and moves every one of them by one step each time a qualified update arrives. The step size is a negative power of two, so multiplying the error by it costs no logic: the error bits are reused with a different radix point. The only real multiplication left is the product of the scaled error with each tap's delayed input sample. That product is formed from two-bit digits of the sample. The signed multiples of the error (×1, ×2, ×3, ×−1, ×−2) are built once and shared by every tap.

A surrounding filter supplies the error, already delayed by its own pipeline, together with the N input samples delayed to line up with that error. It reads the weights back from `w_out` for its inner-product stage. The updater registers its inputs once, keeps one pipeline register inside each tap's shift-add tree, and then accumulates into the weight register. The product is cut to the weight format at both ends: low fractional bits are dropped by floor truncation, and high bits are discarded.

Top module: `lmsu_weight_update`

## Requirements
- R1: While `rst` is high at a rising edge, every weight becomes zero on that edge.
- R2: A qualified update adds to each weight i the increment floor(e·x_i / 2^S), keeping only its low W bits. Here e and x_i are the two's-complement integer values of the error and the sample, and S = L − 2·LI + MU_SHIFT − log2 N. The default is S = 6.
- R3: Samples are signed two's complement. The most significant two-bit digit of each sample has the values 0, +1, −2 and −1 for codes 00, 01, 10 and 11. Negative samples, including the most negative code, give the exact signed product.
- R4: All taps use the same error, and each tap's increment depends only on its own sample field `x_in[i*L +: L]`. Its weight appears at `w_out[i*W +: W]`.
- R5: Inputs sampled at rising edge k with `in_valid` high change `w_out` just after edge k+2. Updates presented on consecutive cycles are each applied once, in order.
- R6: Inputs sampled with `in_valid` low leave every weight unchanged.
- R7: The weight sum is kept to W bits without widening, so an addition past the signed range wraps modulo 2^W.
- R8: Bits of the shifted product above the W-bit weight range are discarded before the addition.
- R9: A tap whose sample is zero receives a zero increment, whatever the error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the error and samples on this cycle as one update |
| err_in | input | W | Delayed error, two's complement |
| x_in | input | N*L | Delayed tap samples; tap i at bits [i*L +: L] |
| w_out | output | N*W | Current weights; tap i at bits [i*W +: W] |

## Verification
Every weight result is due just after the third rising edge, counting the edge that samples the stimulus. The bench drives one item on each falling edge, including idle cycles. With each item it queues the expected weight vector, tagged with the rising-edge count at which that vector becomes visible. The monitor compares each queued vector on the falling edge that follows its due edge. A weight that changes one cycle early or late therefore disagrees with the vector queued for its neighbouring cycle.

// File: rtl/lmsu_pkg.sv
package lmsu_pkg;

    // Multiple of the scaled error selected by one two-bit digit of a sample
    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_ONE,
        SEL_TWO,
        SEL_THREE,
        SEL_NEG_ONE,
        SEL_NEG_TWO
    } pp_sel_e;

    // Digits below the top one are unsigned 0..3; the top digit carries the sign
    function automatic pp_sel_e decode_digit(input logic [1:0] dig, input logic is_top);
        pp_sel_e sel;
        unique case (dig)
            2'b00:   sel = SEL_ZERO;
            2'b01:   sel = SEL_ONE;
            2'b10:   sel = is_top ? SEL_NEG_TWO : SEL_TWO;
            default: sel = is_top ? SEL_NEG_ONE : SEL_THREE;
        endcase
        return sel;
    endfunction

    // Right shift that aligns the error-by-sample product with the weight format
    function automatic int align_shift(input int l, input int li, input int mu, input int lg);
        return l - 2 * li + mu - lg;
    endfunction

endpackage

// File: rtl/lmsu_err_share.sv
module lmsu_err_share #(
    parameter int W = 16
) (
    input  logic [W-1:0]   err,
    output logic [W+1:0]   m_p1,
    output logic [W+1:0]   m_p2,
    output logic [W+1:0]   m_p3,
    output logic [W+1:0]   m_n1,
    output logic [W+1:0]   m_n2
);
    localparam int MW = W + 2;

    logic signed [MW-1:0] e_ext;

    always_comb begin
        e_ext = MW'($signed(err));
        m_p1  = e_ext;
        m_p2  = e_ext <<< 1;
        m_p3  = e_ext + (e_ext <<< 1);
        m_n1  = -e_ext;
        m_n2  = -(e_ext <<< 1);
    end

endmodule

// File: rtl/lmsu_ppg.sv
module lmsu_ppg
    import lmsu_pkg::*;
#(
    parameter int W = 16,
    parameter int L = 8
) (
    input  logic [L-1:0]           x,
    input  logic [W+1:0]           m_p1,
    input  logic [W+1:0]           m_p2,
    input  logic [W+1:0]           m_p3,
    input  logic [W+1:0]           m_n1,
    input  logic [W+1:0]           m_n2,
    output logic [(L/2)*(W+2)-1:0] pp_flat
);
    localparam int MW = W + 2;
    localparam int D  = L / 2;

    for (genvar g = 0; g < D; g++) begin : g_digit
        localparam bit IS_TOP = (g == D - 1);
        pp_sel_e sel;
        always_comb begin
            sel = decode_digit(x[2*g +: 2], IS_TOP);
            pp_flat[g*MW +: MW] = ({MW{sel == SEL_ONE}}     & m_p1)
                                | ({MW{sel == SEL_TWO}}     & m_p2)
                                | ({MW{sel == SEL_THREE}}   & m_p3)
                                | ({MW{sel == SEL_NEG_ONE}} & m_n1)
                                | ({MW{sel == SEL_NEG_TWO}} & m_n2);
        end
    end

endmodule

// File: rtl/lmsu_tap.sv
module lmsu_tap #(
    parameter int W       = 16,
    parameter int L       = 8,
    parameter int SHIFT_R = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_en,
    input  logic [L-1:0] x_a,
    input  logic [W+1:0] m_p1,
    input  logic [W+1:0] m_p2,
    input  logic [W+1:0] m_p3,
    input  logic [W+1:0] m_n1,
    input  logic [W+1:0] m_n2,
    output logic [W-1:0] w_q
);
    localparam int MW = W + 2;
    localparam int D  = L / 2;
    localparam int P  = D / 2;
    localparam int PW = W + L;
    localparam int AW = PW + W;

    logic [D*MW-1:0]      pp_flat;
    logic signed [PW-1:0] psum_n [P];
    logic signed [PW-1:0] psum_q [P];
    logic signed [PW-1:0] prod;
    logic [AW-1:0]        prod_ext;
    logic [W-1:0]         inc;
    logic                 psum_any;

    lmsu_ppg #(.W(W), .L(L)) u_ppg (
        .x       (x_a),
        .m_p1    (m_p1),
        .m_p2    (m_p2),
        .m_p3    (m_p3),
        .m_n1    (m_n1),
        .m_n2    (m_n2),
        .pp_flat (pp_flat)
    );

    // First shift-add level: pairs of neighbouring digits
    always_comb begin
        for (int j = 0; j < P; j++) begin
            logic signed [PW-1:0] lo;
            logic signed [PW-1:0] hi;
            lo = PW'($signed(pp_flat[(2*j)*MW +: MW]));
            hi = PW'($signed(pp_flat[(2*j+1)*MW +: MW]));
            psum_n[j] = lo + (hi <<< 2);
        end
    end

    // Pipeline register inside the shift-add tree
    always_ff @(posedge clk) begin
        for (int j = 0; j < P; j++) begin
            if (rst) psum_q[j] <= '0;
            else     psum_q[j] <= psum_n[j];
        end
    end

    // Remaining levels, alignment and truncation at both ends
    always_comb begin
        prod = '0;
        for (int j = 0; j < P; j++) begin
            prod = prod + (psum_q[j] <<< (4 * j));
        end
        prod_ext = {{W{prod[PW-1]}}, prod};
        inc      = prod_ext[SHIFT_R +: W];
    end

    always_ff @(posedge clk) begin
        if (rst)         w_q <= '0;
        else if (upd_en) w_q <= w_q + inc;
    end

    always_comb begin
        psum_any = 1'b0;
        for (int j = 0; j < P; j++) psum_any = psum_any | (|psum_q[j]);
    end

    AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (x_a == '0) |=> !psum_any) else $error("zero sample left a partial sum"); // R9

endmodule

// File: rtl/lmsu_weight_update.sv
module lmsu_weight_update
    import lmsu_pkg::*;
#(
    parameter int N        = 4,
    parameter int L        = 8,
    parameter int LI       = 2,
    parameter int W        = 16,
    parameter int WI       = 0,
    parameter int MU_SHIFT = LI + $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   err_in,
    input  logic [N*L-1:0] x_in,
    output logic [N*W-1:0] w_out
);
    localparam int LOG2N   = $clog2(N);
    localparam int SHIFT_R = align_shift(L, LI, MU_SHIFT, LOG2N);

    if ((L % 4) != 0 || (1 << LOG2N) != N || MU_SHIFT > WI + LI + LOG2N
        || SHIFT_R < 0 || SHIFT_R > L + W) begin : g_cfg_bad
        $error("lmsu_weight_update: unsupported step shift or word sizes");
    end

    // Input register stage (delays samples and error together)
    logic [N*L-1:0] x_a;
    logic [W-1:0]   e_a;
    logic           vld_a;
    logic           vld_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_a   <= '0;
            e_a   <= '0;
            vld_a <= 1'b0;
            vld_b <= 1'b0;
        end else begin
            x_a   <= x_in;
            e_a   <= err_in;
            vld_a <= in_valid;
            vld_b <= vld_a;
        end
    end

    logic [W+1:0] m_p1, m_p2, m_p3, m_n1, m_n2;

    lmsu_err_share #(.W(W)) u_share (
        .err  (e_a),
        .m_p1 (m_p1),
        .m_p2 (m_p2),
        .m_p3 (m_p3),
        .m_n1 (m_n1),
        .m_n2 (m_n2)
    );

    for (genvar i = 0; i < N; i++) begin : g_tap
        lmsu_tap #(.W(W), .L(L), .SHIFT_R(SHIFT_R)) u_tap (
            .clk    (clk),
            .rst    (rst),
            .upd_en (vld_b),
            .x_a    (x_a[i*L +: L]),
            .m_p1   (m_p1),
            .m_p2   (m_p2),
            .m_p3   (m_p3),
            .m_n1   (m_n1),
            .m_n2   (m_n2),
            .w_q    (w_out[i*W +: W])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (w_out == '0)) else $error("weights not cleared by reset"); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !vld_b |=> $stable(w_out)) else $error("weights moved without update"); // R6

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (vld_b == $past(in_valid, 2)))
        else $error("update qualifier misaligned"); // R5

endmodule

// File: tb/tb_lmsu_weight_update.sv
module tb_lmsu_weight_update;
    localparam int N        = 4;
    localparam int L        = 8;
    localparam int LI       = 2;
    localparam int W        = 16;
    localparam int WI       = 0;
    localparam int MU_SHIFT = 4;
    localparam int SHIFT_R  = L - 2 * LI + MU_SHIFT - 2;

    typedef struct {
        int             due;
        logic [N*W-1:0] w;
        string          req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [W-1:0]   err_in = '0;
    logic [N*L-1:0] x_in = '0;
    logic [N*W-1:0] w_out;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   done    = 1'b0;
    exp_t q[$];
    logic [W-1:0] mw [N];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lmsu_weight_update #(
        .N(N), .L(L), .LI(LI), .W(W), .WI(WI), .MU_SHIFT(MU_SHIFT)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .err_in   (err_in),
        .x_in     (x_in),
        .w_out    (w_out)
    );

    task automatic check_w(input logic [N*W-1:0] exp_w, input string req);
        for (int i = 0; i < N; i++) begin
            n_tests++;
            if (w_out[i*W +: W] !== exp_w[i*W +: W]) begin
                n_fail++;
                $display("FAIL %s tap %0d: got %h expected %h", req, i,
                         w_out[i*W +: W], exp_w[i*W +: W]);
            end
        end
    endtask

    function automatic logic [N*W-1:0] model_vec();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = mw[i];
        return v;
    endfunction

    // Driver: one item per cycle; expected weights queued with their due edge
    task automatic drive(input logic v, input logic [W-1:0] e,
                         input logic [N*L-1:0] xs, input string req);
        exp_t it;
        @(negedge clk);
        in_valid = v;
        err_in   = e;
        x_in     = xs;
        if (v) begin
            for (int i = 0; i < N; i++) begin
                longint prod;
                longint inc;
                prod  = longint'($signed(e)) * longint'($signed(xs[i*L +: L]));
                inc   = prod >>> SHIFT_R;
                mw[i] = mw[i] + inc[W-1:0];
            end
        end
        it.due = cyc + 3;
        it.w   = model_vec();
        it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compares each item on the falling edge after its due edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t it;
                it = q.pop_front();
                check_w(it.w, it.req);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mw[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_w('0, "R1 reset");
        rst = 1'b0;

        // R2 R4: positive error, distinct samples per tap
        drive(1'b1, 16'd1000, {8'd3, 8'd17, 8'd64, 8'd1}, "R2/R4 positive");
        drive(1'b0, 16'd0, '0, "R5 idle after single");
        drive(1'b0, 16'd0, '0, "R5 idle after single");
        drive(1'b0, 16'd0, '0, "R5 idle after single");
        // R3: negative samples including the most negative code
        drive(1'b1, 16'd2500, {8'h80, 8'hFF, 8'hC3, 8'h7F}, "R3 negative samples");
        // R2: negative error, floor truncation of small negative products
        drive(1'b1, 16'hFFFF, {8'd1, 8'hFF, 8'd63, 8'd64}, "R2 floor truncation");
        drive(1'b1, 16'hF000, {8'd5, 8'hFB, 8'd100, 8'h9C}, "R2 negative error");
        // R6: idle cycles with nonzero data present
        drive(1'b0, 16'h7FFF, {8'd127, 8'd127, 8'd127, 8'd127}, "R6 hold");
        drive(1'b0, 16'h1234, {8'h80, 8'd1, 8'd2, 8'd3}, "R6 hold");
        // R9: zero sample on one tap
        drive(1'b1, 16'h4321, {8'd9, 8'd0, 8'hF0, 8'd0}, "R9 zero sample");
        // R5: back-to-back stream
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 16'(k * 911 - 3000),
                  {8'(k * 37), 8'(-k * 5), 8'(k + 100), 8'(k * 13 - 50)}, "R5 stream");
        end
        // R7 R8: large products wrap and upper bits drop
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 16'h7FFF, {8'd127, 8'h80, 8'd127, 8'h81}, "R7/R8 wrap");
        end
        drive(1'b1, 16'h8000, {8'h80, 8'd127, 8'h80, 8'd1}, "R8 extreme product");
        for (int k = 0; k < 4; k++) drive(1'b0, 16'd0, '0, "R6 drain");

        while (q.size() > 0) @(negedge clk);

        // R1: reset in mid-run clears nonzero weights
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < N; i++) mw[i] = '0;
        @(negedge clk);
        check_w('0, "R1 mid-run reset");
        rst = 1'b0;
        drive(1'b1, 16'd300, {8'd2, 8'd4, 8'd8, 8'd16}, "R1/R2 after reset");
        for (int k = 0; k < 4; k++) drive(1'b0, 16'd0, '0, "R6 final");
        while (q.size() > 0) @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule